// File: doc/BRIEF.md
# Macro-Store Bus Cycle Decoder

This block sits next to a 16-bit processor bus and sorts each bus cycle into one of three classes: ordinary memory, macro-store, or I/O. It decodes a 3-bit bus status code together with an active-low memory-select strobe. The class is captured on the clock edge at which the address-latch strobe is high, and it is held until the next latch.

Macro-store status codes also appear during internal ALU cycles. A cycle therefore becomes a real macro-store access only when a read or write strobe is active during it. From the held class and the live strobes, the block produces four things:
- the source select for the read-data multiplexer;
- the write enable of a macro-store RAM window with a configurable base and size;
- a wait request that stretches only real macro-store accesses;
- a redirect of flagged loads from a cartridge window into a separate ROM space.

Three saturating debug counters, cleared synchronously, let a host see how often macro-store activity appears on the bus.

Top module: `msb_cycle_decoder`

## Requirements
- R1: On a clock edge with `latch` high, `cyc_class` takes the class of the bus status, and it holds that value until the next such edge. The encodings are: 0 memory when `memsel_n` is low; 1 macro when `memsel_n` is high and `bus_st` is 000 or 001; 2 I/O for any other code with `memsel_n` high.
- R2: A macro-class cycle with both `rd_n` and `wr_n` high is an ALU cycle. During it, `ready` stays high, `ms_we` stays low and `rd_src` selects I/O.
- R3: The `rd_src` encodings are 0 RAM, 1 macro-store, 2 I/O and 3 alternate ROM. Memory class gives RAM, or alternate ROM per R5. Macro class with `rd_n` low gives macro-store. Every other case gives I/O.
- R4: `ms_we` is high exactly when the class is macro, `wr_n` is low, and the latched address lies in [MS_BASE, MS_BASE+MS_SIZE).
- R5: A latched memory-class cycle raises `alt_rom` and makes `rd_src` select 3 when two conditions hold: `prog_sel` was high at the latch, and the address lies in [CART_BASE, CART_BASE+CART_SIZE). With the default CART_BASE of 0x6000, the redirected access uses the same address in the alternate ROM space.
- R6: `ms_rd_cnt` increases by one for each macro-store read, counted at the clock where `rd_n` goes from high to low while the class is macro.
- R7: `code_cnt` increases on every clock edge where the live inputs show a macro status code: `memsel_n` high and `bus_st` 000 or 001.
- R8: `code_rd_cnt` increases on every clock edge where a macro status code is present and `rd_n` is low.
- R9: All counters are CNT_W bits wide and stop at all-ones.
- R10: `dbg_clr` zeroes all counters on the next edge and takes priority over any increment.
- R11: During a real macro-store access, `ready` is low for the first MS_WAIT clocks of the strobe and high afterwards. `ready` is never low without a strobe.
- R12: While reset is asserted, the outputs are: class I/O, `ready` high, `ms_we` low, `alt_rom` low, and all counters zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| latch | input | 1 | Address-latch phase; the class is captured on this edge |
| addr | input | AW | Bus address |
| bus_st | input | 3 | Bus status code |
| memsel_n | input | 1 | Memory select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| prog_sel | input | 1 | Program-select flag, sampled at the latch |
| dbg_clr | input | 1 | Synchronous clear of the debug counters |
| cyc_class | output | 2 | Held cycle class (0 memory, 1 macro, 2 I/O) |
| rd_src | output | 2 | Read-data multiplexer select |
| ms_we | output | 1 | Macro-store RAM write enable |
| alt_rom | output | 1 | Load redirected to the alternate ROM |
| ready | output | 1 | Low requests a wait state |
| ms_rd_cnt | output | CNT_W | Macro-store read counter |
| code_cnt | output | CNT_W | Clocks with a macro status code present |
| code_rd_cnt | output | CNT_W | Clocks with a macro code and an active read |

## Verification
The assertions check several properties on every cycle:
- the class holds between latches;
- ALU cycles stay quiet (no wait, no write, I/O data selected);
- the write enable needs a write strobe;
- the redirect occurs only in memory class;
- the wait request needs a strobe;
- the counters stand still without their event, saturate, and clear.

Only the bench scenarios can show the rest. These are the exact class chosen for each status combination, the window edges for writes and for the cartridge redirect, the length of the wait-state stretch, and the counter values after mixed traffic. A behavioural model compares all of these on every clock.

// File: rtl/msb_pkg.sv
package msb_pkg;

  typedef enum logic [1:0] {
    CLS_MEM   = 2'd0,
    CLS_MACRO = 2'd1,
    CLS_IO    = 2'd2
  } cyc_cls_e;

  typedef enum logic [1:0] {
    SRC_RAM   = 2'd0,
    SRC_MACRO = 2'd1,
    SRC_IO    = 2'd2,
    SRC_ALT   = 2'd3
  } rd_src_e;

  // Status code shared by macro-store and internal ALU cycles
  function automatic logic macro_code(input logic [2:0] st, input logic memsel_n);
    return memsel_n && (st[2:1] == 2'b00);
  endfunction

  // Half-open window test: base <= a < base + size
  function automatic logic in_window(input logic [31:0] a, input logic [31:0] base,
                                     input logic [31:0] size);
    return (a >= base) && ((a - base) < size);
  endfunction

endpackage

// File: rtl/msb_decode.sv
module msb_decode
  import msb_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MS_BASE   = 'h0800,
  parameter int MS_SIZE   = 'h1000,
  parameter int CART_BASE = 'h6000,
  parameter int CART_SIZE = 'h2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    bus_st,
  input  logic          memsel_n,
  input  logic          prog_sel,
  output cyc_cls_e      cls,
  output logic          in_mswin,
  output logic          alt_hit
);
  logic [31:0] addr_w;
  cyc_cls_e    cls_nxt;

  assign addr_w = 32'(addr);

  always_comb begin
    if (!memsel_n)                    cls_nxt = CLS_MEM;
    else if (macro_code(bus_st, 1'b1)) cls_nxt = CLS_MACRO;
    else                              cls_nxt = CLS_IO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls      <= CLS_IO;
      in_mswin <= 1'b0;
      alt_hit  <= 1'b0;
    end else if (latch) begin
      cls      <= cls_nxt;
      in_mswin <= in_window(addr_w, 32'(MS_BASE), 32'(MS_SIZE));
      alt_hit  <= !memsel_n && prog_sel &&
                  in_window(addr_w, 32'(CART_BASE), 32'(CART_SIZE));
    end
  end

endmodule

// File: rtl/msb_route.sv
module msb_route
  import msb_pkg::*;
#(
  parameter int MS_WAIT = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cyc_cls_e cls,
  input  logic     in_mswin,
  input  logic     alt_hit,
  input  logic     rd_n,
  input  logic     wr_n,
  output rd_src_e  rd_src,
  output logic     ms_we,
  output logic     ready,
  output logic     ms_rd_evt
);
  localparam int WW = $clog2(MS_WAIT + 2);

  logic ms_acc;
  logic rd_q;

  assign ms_acc    = (cls == CLS_MACRO) && (!rd_n || !wr_n);
  assign ms_rd_evt = (cls == CLS_MACRO) && !rd_n && rd_q;
  assign ms_we     = (cls == CLS_MACRO) && !wr_n && in_mswin;

  always_comb begin
    case (cls)
      CLS_MEM:   rd_src = alt_hit ? SRC_ALT : SRC_RAM;
      CLS_MACRO: rd_src = !rd_n ? SRC_MACRO : SRC_IO;
      default:   rd_src = SRC_IO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b1;
    else        rd_q <= rd_n;
  end

  generate
    if (MS_WAIT == 0) begin : g_nowait
      assign ready = 1'b1;
    end else begin : g_wait
      localparam logic [WW-1:0] WLIM = WW'(MS_WAIT);
      logic [WW-1:0] wcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     wcnt <= '0;
        else if (!ms_acc)               wcnt <= '0;
        else if (wcnt < WLIM)           wcnt <= wcnt + 1'b1;
      end
      assign ready = !(ms_acc && (wcnt < WLIM));
    end
  endgenerate

endmodule

// File: rtl/msb_satcnt.sv
module msb_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q <= '0;
    else if (clr)          q <= '0;
    else if (inc && !(&q)) q <= q + 1'b1;
  end
endmodule

// File: rtl/msb_cycle_decoder.sv
module msb_cycle_decoder
  import msb_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MS_BASE   = 'h0800,
  parameter int MS_SIZE   = 'h1000,
  parameter int CART_BASE = 'h6000,
  parameter int CART_SIZE = 'h2000,
  parameter int MS_WAIT   = 2,
  parameter int CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch,
  input  logic [AW-1:0]    addr,
  input  logic [2:0]       bus_st,
  input  logic             memsel_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             prog_sel,
  input  logic             dbg_clr,
  output logic [1:0]       cyc_class,
  output logic [1:0]       rd_src,
  output logic             ms_we,
  output logic             alt_rom,
  output logic             ready,
  output logic [CNT_W-1:0] ms_rd_cnt,
  output logic [CNT_W-1:0] code_cnt,
  output logic [CNT_W-1:0] code_rd_cnt
);
  localparam int NCNT = 3;

  cyc_cls_e cls;
  rd_src_e  src;
  logic     in_mswin;
  logic     alt_hit;
  logic     ms_rd_evt;
  logic     code_now;
  logic     code_rd_now;
  logic [NCNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_q [NCNT];

  msb_decode #(
    .AW(AW), .MS_BASE(MS_BASE), .MS_SIZE(MS_SIZE),
    .CART_BASE(CART_BASE), .CART_SIZE(CART_SIZE)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .latch(latch), .addr(addr), .bus_st(bus_st),
    .memsel_n(memsel_n), .prog_sel(prog_sel),
    .cls(cls), .in_mswin(in_mswin), .alt_hit(alt_hit)
  );

  msb_route #(.MS_WAIT(MS_WAIT)) u_route (
    .clk(clk), .rst_n(rst_n), .cls(cls), .in_mswin(in_mswin), .alt_hit(alt_hit),
    .rd_n(rd_n), .wr_n(wr_n), .rd_src(src), .ms_we(ms_we), .ready(ready),
    .ms_rd_evt(ms_rd_evt)
  );

  assign code_now    = macro_code(bus_st, memsel_n);
  assign code_rd_now = code_now && !rd_n;
  assign cnt_inc     = {code_rd_now, code_now, ms_rd_evt};

  generate
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
      msb_satcnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(dbg_clr), .inc(cnt_inc[g]), .q(cnt_q[g])
      );
    end
  endgenerate

  assign cyc_class   = cls;
  assign rd_src      = src;
  assign alt_rom     = alt_hit && (cls == CLS_MEM);
  assign ms_rd_cnt   = cnt_q[0];
  assign code_cnt    = cnt_q[1];
  assign code_rd_cnt = cnt_q[2];

endmodule

// File: rtl/msb_cycle_decoder_chk.sv
module msb_cycle_decoder_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             latch,
  input logic             rd_n,
  input logic             wr_n,
  input logic             dbg_clr,
  input logic [1:0]       cyc_class,
  input logic [1:0]       rd_src,
  input logic             ms_we,
  input logic             alt_rom,
  input logic             ready,
  input logic             ms_rd_evt,
  input logic             code_now,
  input logic [CNT_W-1:0] ms_rd_cnt,
  input logic [CNT_W-1:0] code_cnt,
  input logic [CNT_W-1:0] code_rd_cnt
);
  // R1
  a_r1_class_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(cyc_class));
  // R2
  a_r2_alu_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_class == 2'd1 && rd_n && wr_n) |-> (ready && !ms_we && rd_src == 2'd2));
  // R4
  a_r4_we_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ms_we |-> (!wr_n && cyc_class == 2'd1));
  // R5
  a_r5_alt_mem: assert property (@(posedge clk) disable iff (!rst_n)
    alt_rom |-> (cyc_class == 2'd0 && rd_src == 2'd3));
  // R6
  a_r6_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_clr && !ms_rd_evt) |=> $stable(ms_rd_cnt));
  // R7
  a_r7_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_clr && !code_now) |=> $stable(code_cnt));
  // R9
  a_r9_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_clr && (&code_cnt)) |=> (&code_cnt));
  // R10
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_clr |=> (ms_rd_cnt == '0 && code_cnt == '0 && code_rd_cnt == '0));
  // R11
  a_r11_wait_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!rd_n || !wr_n));
endmodule

bind msb_cycle_decoder msb_cycle_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch(latch), .rd_n(rd_n), .wr_n(wr_n),
  .dbg_clr(dbg_clr), .cyc_class(cyc_class), .rd_src(rd_src), .ms_we(ms_we),
  .alt_rom(alt_rom), .ready(ready), .ms_rd_evt(ms_rd_evt), .code_now(code_now),
  .ms_rd_cnt(ms_rd_cnt), .code_cnt(code_cnt), .code_rd_cnt(code_rd_cnt)
);

// File: tb/msb_cycle_decoder_tb_top.sv
module msb_cycle_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 6;
  localparam int WT   = 2;
  localparam int MSB  = 'h0800;
  localparam int MSS  = 'h1000;
  localparam int CB   = 'h6000;
  localparam int CS   = 'h2000;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch = 1'b0;
  logic [15:0] addr = '0;
  logic [2:0]  bus_st = 3'b111;
  logic memsel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, prog_sel = 1'b0, dbg_clr = 1'b0;
  logic [1:0] cyc_class, rd_src;
  logic ms_we, alt_rom, ready;
  logic [CW-1:0] ms_rd_cnt, code_cnt, code_rd_cnt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msb_cycle_decoder #(
    .AW(16), .MS_BASE(MSB), .MS_SIZE(MSS), .CART_BASE(CB), .CART_SIZE(CS),
    .MS_WAIT(WT), .CNT_W(CW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .latch(latch), .addr(addr), .bus_st(bus_st),
    .memsel_n(memsel_n), .rd_n(rd_n), .wr_n(wr_n), .prog_sel(prog_sel),
    .dbg_clr(dbg_clr), .cyc_class(cyc_class), .rd_src(rd_src), .ms_we(ms_we),
    .alt_rom(alt_rom), .ready(ready), .ms_rd_cnt(ms_rd_cnt), .code_cnt(code_cnt),
    .code_rd_cnt(code_rd_cnt)
  );

  // Behavioural reference state
  int m_cls = 2;
  bit m_win = 0, m_alt = 0, m_rdq = 1;
  int m_w = 0;
  int c_rd = 0, c_code = 0, c_coderd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cls = 2; m_win = 0; m_alt = 0; m_rdq = 1; m_w = 0;
      c_rd = 0; c_code = 0; c_coderd = 0;
    end else begin
      bit acc, evt, codep;
      acc   = (m_cls == 1) && (rd_n == 1'b0 || wr_n == 1'b0);
      evt   = (m_cls == 1) && rd_n == 1'b0 && m_rdq;
      codep = memsel_n == 1'b1 && int'(bus_st) <= 1;
      if (dbg_clr) begin
        c_rd = 0; c_code = 0; c_coderd = 0;
      end else begin
        if (evt && c_rd < CMAX) c_rd++;
        if (codep && c_code < CMAX) c_code++;
        if (codep && rd_n == 1'b0 && c_coderd < CMAX) c_coderd++;
      end
      if (!acc) m_w = 0;
      else if (m_w < WT) m_w++;
      m_rdq = rd_n;
      if (latch) begin
        int a;
        a = int'(addr);
        if (memsel_n == 1'b0) m_cls = 0;
        else if (int'(bus_st) <= 1) m_cls = 1;
        else m_cls = 2;
        m_win = (a >= MSB) && (a < MSB + MSS);
        m_alt = (memsel_n == 1'b0) && prog_sel && (a >= CB) && (a < CB + CS);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        int esrc;
        bit acc;
        acc = (m_cls == 1) && (rd_n == 1'b0 || wr_n == 1'b0);
        if (m_cls == 0) esrc = m_alt ? 3 : 0;
        else if (m_cls == 1) esrc = (rd_n == 1'b0) ? 1 : 2;
        else esrc = 2;
        chk("R1 cyc_class", int'(cyc_class), m_cls);
        chk("R3 rd_src", int'(rd_src), esrc);
        chk("R4 ms_we", int'(ms_we), int'(m_cls == 1 && wr_n == 1'b0 && m_win));
        chk("R5 alt_rom", int'(alt_rom), int'(m_alt && m_cls == 0));
        chk("R11 ready", int'(ready), int'(!(acc && m_w < WT)));
        chk("R6 ms_rd_cnt", int'(ms_rd_cnt), c_rd);
        chk("R7 code_cnt", int'(code_cnt), c_code);
        chk("R8 code_rd_cnt", int'(code_rd_cnt), c_coderd);
      end
    end
  end

  task automatic bus_cyc(input logic [15:0] a, input logic [2:0] st, input logic msn,
                         input logic ps, input logic do_rd, input logic do_wr, input int n);
    @(negedge clk);
    addr = a; bus_st = st; memsel_n = msn; prog_sel = ps; latch = 1'b1;
    rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    latch = 1'b0;
    for (int i = 0; i < n; i++) begin
      rd_n = !do_rd; wr_n = !do_wr;
      @(negedge clk);
    end
    rd_n = 1'b1; wr_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    // R12 reset state
    chk("R12 class", int'(cyc_class), 2);
    chk("R12 ready", int'(ready), 1);
    chk("R12 ms_we", int'(ms_we), 0);
    chk("R12 alt_rom", int'(alt_rom), 0);
    chk("R12 counters", int'(ms_rd_cnt) + int'(code_cnt) + int'(code_rd_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;

    bus_cyc(16'h2000, 3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 2); // memory read
    bus_cyc(16'h6000, 3'b100, 1'b0, 1'b1, 1'b1, 1'b0, 2); // cartridge redirect
    #(CLK_PERIOD/4);
    chk("R5 alt held", int'(alt_rom), 1);
    bus_cyc(16'h7FFF, 3'b100, 1'b0, 1'b1, 1'b1, 1'b0, 1); // top of cartridge
    bus_cyc(16'h8000, 3'b100, 1'b0, 1'b1, 1'b1, 1'b0, 1); // just past it
    bus_cyc(16'h6000, 3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 1); // flag clear
    bus_cyc(16'h0800, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 4); // macro read
    bus_cyc(16'h0802, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 3); // macro write in window
    bus_cyc(16'h17FF, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 2); // last window word
    bus_cyc(16'h1800, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 2); // outside window
    bus_cyc(16'h07FE, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 2); // below window
    bus_cyc(16'h0900, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 3); // ALU cycle
    #(CLK_PERIOD/4);
    // R2: ALU cycle is ignored
    chk("R2 ready", int'(ready), 1);
    chk("R2 ms_we", int'(ms_we), 0);
    chk("R2 rd_src", int'(rd_src), 2);
    bus_cyc(16'h0040, 3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 2); // I/O read
    bus_cyc(16'h0044, 3'b110, 1'b1, 1'b0, 1'b0, 1'b1, 2); // I/O write
    bus_cyc(16'h0A00, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 1); // short macro read

    // R10 clear while events pending
    @(negedge clk);
    bus_st = 3'b000; memsel_n = 1'b1; rd_n = 1'b0; dbg_clr = 1'b1;
    @(negedge clk);
    dbg_clr = 1'b0;
    #(CLK_PERIOD/4);
    chk("R10 ms_rd_cnt", int'(ms_rd_cnt), 0);
    chk("R10 code_cnt", int'(code_cnt), 0);

    // R9 saturation under a long run of macro code with read
    repeat (CMAX + 8) @(negedge clk);
    #(CLK_PERIOD/4);
    chk("R9 code_cnt", int'(code_cnt), CMAX);
    chk("R9 code_rd_cnt", int'(code_rd_cnt), CMAX);
    @(negedge clk);
    rd_n = 1'b1; bus_st = 3'b111; dbg_clr = 1'b1;
    @(negedge clk);
    dbg_clr = 1'b0;
    #(CLK_PERIOD/4);
    chk("R10 code_rd_cnt", int'(code_rd_cnt), 0);

    bus_cyc(16'h0C00, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 3);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule